// File: doc/BRIEF.md
# DMA Channel Arm and Abort Control Register

This block holds the arm state for five DMA channels and turns bus writes into arm, disarm and abort actions. A channel may move bytes or words only while its arm bit is set. The transfer engine, which sits outside this block, reports when each channel reaches its transfer count. A channel in a single-shot (non-repetitive) mode then loses its arm bit on its own. A channel in a repetitive mode keeps it.

A bus write with the command bit (bit 7) at 0 loads all five arm bits from the written data. A write with bit 7 at 1 is an abort command. Its low five bits then select the channels to stop: each selected channel is disarmed and gets a one-cycle abort pulse, and channels that are not selected are left alone. Each channel also has an interrupt-enable input. When a channel completes its count with that input high, its interrupt request fires.

Top module: `dma_arm_ctrl`

## Requirements
- R1: After a synchronous active-low reset, the arm outputs, abort pulses, interrupt requests and read data are all 0.
- R2: A write with bit 7 at 0 loads the arm bits for channels 4..0 from write data bits 4..0, and the new value is visible on the clock edge that takes the write.
- R3: When a channel in single-shot mode (its repeat input at 0) reports count reached, and no write is taken that cycle, its arm bit is 0 after that edge.
- R4: When a channel in repetitive mode (its repeat input at 1) reports count reached, its arm bit keeps its value.
- R5: A write with bit 7 at 1 clears the arm bit of each channel whose bit in data 4..0 is 1. It drives that channel's abort output high for exactly the one cycle after the write. Channels whose bit is 0 keep their arm bit and get no abort pulse.
- R6: Read data bits 4..0 show the arm bits. Bits 7..5 always read 0, and a write to bits 6..5 has no effect.
- R7: A count-reached report with the channel's interrupt enable at 1 raises that channel's interrupt output for the one cycle after the report. With the enable at 0, no interrupt is raised.
- R8: When a write and a single-shot count-reached report hit the same channel in the same cycle, the arm bit takes the written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_wr | input | 1 | Write strobe for the control register |
| bus_wdata | input | 8 | Write data: bit 7 is the abort command, bits 4..0 are the channel bits |
| bus_rdata | output | 8 | Read data: arm bits in 4..0, zeros above |
| cnt_reached | input | 5 | Per-channel pulse that the transfer count was reached |
| repeat_mode | input | 5 | Per-channel flag for repetitive transfer mode |
| irq_enable | input | 5 | Per-channel interrupt enable |
| chan_armed | output | 5 | Per-channel arm state |
| chan_abort | output | 5 | Per-channel one-cycle abort pulse |
| chan_irq | output | 5 | Per-channel interrupt request pulse |

## Verification
The assertions assume that every input is a clean 0 or 1 at each sampled edge, and that a count-reached report lasts one cycle. Both the interrupt check and the disarm check read the report one cycle after it arrives. The stimulus drives all inputs on the falling edge and returns the strobes and reports to 0 after each vector. This keeps every report to a single cycle. The bench still tests a report that coincides with a write, since that case has a defined winner.

// File: rtl/dma_arm_pkg.sv
// Shared constants for the DMA arm/abort control register.
// Assumes an 8-bit bus word, with the command bit above the channel bits.
package dma_arm_pkg;
    localparam int unsigned CHAN_COUNT = 5;
    localparam int unsigned BUS_W      = 8;
    localparam int unsigned CMD_BIT    = 7;
endpackage

// File: rtl/dma_arm_decode.sv
// Turns one bus write into per-channel load and abort-select strobes.
// Assumes the command bit sits above all channel bits within the bus word.
module dma_arm_decode #(
    parameter int unsigned CHANS   = dma_arm_pkg::CHAN_COUNT,
    parameter int unsigned DATA_W  = dma_arm_pkg::BUS_W,
    parameter int unsigned CMD_POS = dma_arm_pkg::CMD_BIT
) (
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [CHANS-1:0]  load_en,
    output logic [CHANS-1:0]  load_val,
    output logic [CHANS-1:0]  abort_sel
);
    logic is_abort;

    // Separate a plain arm write from an abort command.
    always_comb begin
        is_abort  = wr_data[CMD_POS];
        load_val  = wr_data[CHANS-1:0];
        load_en   = (wr_en && !is_abort) ? {CHANS{1'b1}} : '0;
        abort_sel = (wr_en &&  is_abort) ? wr_data[CHANS-1:0] : '0;
    end
endmodule

// File: rtl/dma_arm_chan.sv
// One channel slice: it holds the arm bit, makes the abort pulse and registers the interrupt.
// Assumes load_en and abort_sel are never high together, which the decoder ensures.
module dma_arm_chan (
    input  logic clk,
    input  logic rst_n,
    input  logic load_en,
    input  logic load_val,
    input  logic abort_sel,
    input  logic done,
    input  logic rpt,
    input  logic irq_en,
    output logic armed,
    output logic abort_pulse,
    output logic irq
);
    // Arm state: an abort wins, then a bus load, then the single-shot auto-disarm.
    always_ff @(posedge clk) begin
        if (!rst_n)          armed <= 1'b0;
        else if (abort_sel)  armed <= 1'b0;
        else if (load_en)    armed <= load_val;
        else if (done && !rpt) armed <= 1'b0;
    end

    // One-cycle abort pulse that follows an abort select.
    always_ff @(posedge clk) begin
        if (!rst_n) abort_pulse <= 1'b0;
        else        abort_pulse <= abort_sel;
    end

    // Interrupt request on count completion, gated by the enable.
    always_ff @(posedge clk) begin
        if (!rst_n) irq <= 1'b0;
        else        irq <= done && irq_en;
    end

    // R3: a single-shot completion with no write disarms the channel.
    a_r3_auto_disarm: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !rpt && !load_en && !abort_sel) |=> !armed);
    // R4: a repetitive completion keeps the arm state.
    a_r4_repeat_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (done && rpt && !load_en && !abort_sel) |=> $stable(armed));
    // R5: an abort select disarms the channel and pulses the abort output.
    a_r5_abort_clears: assert property (@(posedge clk) disable iff (!rst_n)
        abort_sel |=> (!armed && abort_pulse));
    // R5: the pulse ends after one cycle unless another abort arrives.
    a_r5_abort_single: assert property (@(posedge clk) disable iff (!rst_n)
        !abort_sel |=> !abort_pulse);
    // R2 and R8: a load takes effect even alongside a completion.
    a_r8_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
        load_en |=> (armed == $past(load_val)));
    // R7: an enabled completion raises the interrupt, and a masked one does not.
    a_r7_irq_follow: assert property (@(posedge clk) disable iff (!rst_n)
        (done && irq_en) |=> irq);
    a_r7_irq_masked: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && irq_en) |=> !irq);
endmodule

// File: rtl/dma_arm_ctrl.sv
// Top of the DMA arm/abort control register for five channels.
// Assumes one bus write per cycle and a single-cycle count-reached report from the engine.
module dma_arm_ctrl #(
    parameter int unsigned CHANS   = dma_arm_pkg::CHAN_COUNT,
    parameter int unsigned DATA_W  = dma_arm_pkg::BUS_W,
    parameter int unsigned CMD_POS = dma_arm_pkg::CMD_BIT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [CHANS-1:0]  cnt_reached,
    input  logic [CHANS-1:0]  repeat_mode,
    input  logic [CHANS-1:0]  irq_enable,
    output logic [CHANS-1:0]  chan_armed,
    output logic [CHANS-1:0]  chan_abort,
    output logic [CHANS-1:0]  chan_irq
);
    localparam int unsigned PAD_W = DATA_W - CHANS;

    logic [CHANS-1:0] load_en;
    logic [CHANS-1:0] load_val;
    logic [CHANS-1:0] abort_sel;

    dma_arm_decode #(.CHANS(CHANS), .DATA_W(DATA_W), .CMD_POS(CMD_POS)) decode_i (
        .wr_en    (bus_wr),
        .wr_data  (bus_wdata),
        .load_en  (load_en),
        .load_val (load_val),
        .abort_sel(abort_sel)
    );

    for (genvar g = 0; g < CHANS; g++) begin : g_chan
        dma_arm_chan chan_i (
            .clk        (clk),
            .rst_n      (rst_n),
            .load_en    (load_en[g]),
            .load_val   (load_val[g]),
            .abort_sel  (abort_sel[g]),
            .done       (cnt_reached[g]),
            .rpt        (repeat_mode[g]),
            .irq_en     (irq_enable[g]),
            .armed      (chan_armed[g]),
            .abort_pulse(chan_abort[g]),
            .irq        (chan_irq[g])
        );
    end

    // Read-back: the arm bits sit at the bottom, and the command and unused bits read 0.
    always_comb bus_rdata = {{PAD_W{1'b0}}, chan_armed};

    // R5: an abort write leaves the channels that are not selected untouched.
    a_r5_unselected_keep: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_wdata[CMD_POS] && cnt_reached == '0)
        |=> ((chan_armed & ~$past(bus_wdata[CHANS-1:0]))
             == ($past(chan_armed) & ~$past(bus_wdata[CHANS-1:0]))));
    // R1: every output is 0 on the cycle after a reset.
    a_r1_reset_clear: assert property (@(posedge clk)
        !rst_n |=> (chan_armed == '0 && chan_abort == '0 && chan_irq == '0));
endmodule

// File: tb/dma_arm_ctrl_tb_top.sv
`timescale 1ns/1ps
module dma_arm_ctrl_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [4:0] cnt_reached = '0;
    logic [4:0] repeat_mode = '0;
    logic [4:0] irq_enable = '0;
    logic [4:0] chan_armed;
    logic [4:0] chan_abort;
    logic [4:0] chan_irq;

    int checks = 0;
    int fails  = 0;
    bit done_flag = 1'b0;

    always #2.5 clk = ~clk;

    dma_arm_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .cnt_reached(cnt_reached), .repeat_mode(repeat_mode),
        .irq_enable(irq_enable), .chan_armed(chan_armed), .chan_abort(chan_abort),
        .chan_irq(chan_irq)
    );

    // Vector fields: wr, wdata[8], done[5], rpt[5], ien[5], exp_arm[5], exp_abort[5], exp_irq[5].
    localparam int NV = 12;
    localparam logic [38:0] VEC [0:NV-1] = '{
        {1'b1, 8'h1F, 5'h00, 5'h00, 5'h00, 5'h1F, 5'h00, 5'h00}, // R2 arm all
        {1'b0, 8'h00, 5'h01, 5'h00, 5'h00, 5'h1E, 5'h00, 5'h00}, // R3 single-shot disarm ch0
        {1'b0, 8'h00, 5'h02, 5'h02, 5'h00, 5'h1E, 5'h00, 5'h00}, // R4 repetitive keeps ch1
        {1'b1, 8'h86, 5'h00, 5'h00, 5'h00, 5'h18, 5'h06, 5'h00}, // R5 abort ch1 and ch2
        {1'b0, 8'h00, 5'h00, 5'h00, 5'h00, 5'h18, 5'h00, 5'h00}, // R5 pulse lasts one cycle
        {1'b0, 8'h00, 5'h08, 5'h08, 5'h08, 5'h18, 5'h00, 5'h08}, // R7 enabled interrupt ch3
        {1'b0, 8'h00, 5'h00, 5'h00, 5'h00, 5'h18, 5'h00, 5'h00}, // R7 interrupt one cycle
        {1'b0, 8'h00, 5'h10, 5'h10, 5'h00, 5'h18, 5'h00, 5'h00}, // R7 masked ch4
        {1'b1, 8'h03, 5'h03, 5'h00, 5'h00, 5'h03, 5'h00, 5'h00}, // R8 write beats disarm
        {1'b1, 8'hE0, 5'h00, 5'h00, 5'h00, 5'h03, 5'h00, 5'h00}, // R6 abort with no channel selected
        {1'b1, 8'h60, 5'h00, 5'h00, 5'h00, 5'h00, 5'h00, 5'h00}, // R6 unused bits ignored
        {1'b1, 8'h81, 5'h00, 5'h00, 5'h00, 5'h00, 5'h01, 5'h00}  // R5 abort idle ch0
    };

    function automatic string tag_of(int i);
        case (i)
            0: return "R2"; 1: return "R3"; 2: return "R4";
            3, 4, 11: return "R5";
            5, 6, 7: return "R7";
            8: return "R8";
            default: return "R6";
        endcase
    endfunction

    task automatic check(string req, string what, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic check_all(string req, logic [4:0] a, logic [4:0] ab, logic [4:0] q);
        check(req, "armed", {3'b0, chan_armed}, {3'b0, a});
        check(req, "abort", {3'b0, chan_abort}, {3'b0, ab});
        check(req, "irq",   {3'b0, chan_irq},   {3'b0, q});
        check("R6", "rdata", bus_rdata, {3'b0, a});
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check_all("R1", 5'h00, 5'h00, 5'h00);  // R1 state after reset
        for (int i = 0; i < NV; i++) begin
            bus_wr      = VEC[i][38];
            bus_wdata   = VEC[i][37:30];
            cnt_reached = VEC[i][29:25];
            repeat_mode = VEC[i][24:20];
            irq_enable  = VEC[i][19:15];
            @(negedge clk);
            bus_wr = 1'b0; cnt_reached = '0;
            check_all(tag_of(i), VEC[i][14:10], VEC[i][9:5], VEC[i][4:0]);
        end
        // R1: a reset in mid-run clears everything, even with activity on the inputs.
        bus_wr = 1'b1; bus_wdata = 8'h1F;
        @(negedge clk);
        bus_wr = 1'b0;
        check_all("R2", 5'h1F, 5'h00, 5'h00);
        rst_n = 1'b0; cnt_reached = 5'h1F; irq_enable = 5'h1F; repeat_mode = 5'h1F;
        @(negedge clk);
        cnt_reached = '0;
        check_all("R1", 5'h00, 5'h00, 5'h00);
        rst_n = 1'b1;
        // R7: all channels raise their interrupts together.
        cnt_reached = 5'h1F;
        @(negedge clk);
        cnt_reached = '0;
        check_all("R7", 5'h00, 5'h00, 5'h1F);
        done_flag = 1'b1;
    end

    initial begin
        fork
            wait (done_flag);
            begin
                repeat (10000) @(posedge clk);
                checks++; fails++;
                $display("FAIL watchdog actual=timeout expected=finish");
            end
        join_any
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule